// File: doc/BRIEF.md
# Serial Character Transmitter with Fractional Stop Period

This block turns parallel characters into an asynchronous serial stream. A character of 5 to 8 data bits is taken over a valid/ready handshake and sent least significant bit first. A low start bit comes before the data. An optional parity bit follows the data, and a high stop period closes the character. Bit timing comes from a single-cycle enable pulse, `tick`, that normally runs at sixteen times the bit rate. Each start, data and parity bit lasts sixteen ticks. The stop period can be set in sixteenths of a bit. When `cfg_x1` is set, each tick is one whole bit and only one or two whole stop bits are available.

A clear-to-send input can hold back the start of each character. The transmitter looks at it only when a character is about to begin. Once a character has begun it always finishes, whatever happens to that input. Every configuration value is captured when a character is accepted, so a setting changed mid-character applies from the next character onward.

Top module: `sertx_core`

## Requirements
- R1: After reset `tx_out` is 1, and `in_ready` is 1 while the clear-to-send gate is off.
- R2: An accepted character is sent as one start slot at 0, then the low `cfg_len`+5 bits of `in_data` (`cfg_len` 0..3 selects 5..8 bits) in order from bit 0 upward. Each slot lasts 16 ticks. Data bits above the selected length are never sent.
- R3: With `cfg_par_en`=1, one parity slot follows the last data bit. `cfg_par_mode` selects the parity: 0 = even (XOR of the sent data bits), 1 = odd (its complement), 2 = constant 0, 3 = constant 1. With `cfg_par_en`=0, no parity slot is sent.
- R4: For lengths of 6 to 8 bits in 16x mode, the stop period is high for 9+n ticks when the stop code n is 0..7, and for 17+n ticks when n is 8..15.
- R5: For 5-bit characters in 16x mode, the stop period is high for 17+n ticks for every stop code n.
- R6: With `cfg_x1`=1, every start, data and parity slot lasts 1 tick. The stop period lasts 1 tick when bit 3 of `cfg_stop` is 0 and 2 ticks when it is 1, and the other code bits are ignored.
- R7: With `cfg_cts_en`=1 and `cts_ok`=0, no character starts: `in_ready` stays 0 and `tx_out` stays 1. The character starts once `cts_ok` becomes 1.
- R8: Dropping `cts_ok` after a character has been accepted does not change that character, including its stop period.
- R9: With `cfg_cts_en`=0, the value of `cts_ok` has no effect on starting or sending.
- R10: Length, parity settings, stop code and clock mode are captured when a character is accepted. Changing them during that character does not alter its waveform.
- R11: `in_ready` is 0 during the start, data and parity slots and the non-final stop ticks. It is 1 in the final stop tick, so a waiting character's start bit follows the stop period with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-timing enable: 16x rate, or the bit rate when `cfg_x1`=1 |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character bits, bit 0 sent first |
| in_ready | output | 1 | Character accepted on a clock edge where both valid and ready are high |
| cfg_len | input | 2 | Data length select, 0..3 = 5..8 bits |
| cfg_par_en | input | 1 | Send a parity slot |
| cfg_par_mode | input | 2 | 0 even, 1 odd, 2 constant 0, 3 constant 1 |
| cfg_stop | input | 4 | Stop period code |
| cfg_cts_en | input | 1 | Gate the start of each character on `cts_ok` |
| cfg_x1 | input | 1 | Each tick is one whole bit |
| cts_ok | input | 1 | Clear to send, 1 = allowed |
| tx_out | output | 1 | Serial line, idles high |

## Verification
The bench tests the edges of the stop encoding: codes 7 and 8 either side of the jump for long characters, and codes 0 and 15 for 5-bit characters. A design that applied one formula to every length would produce a stop period eight ticks short on 5-bit characters. It also drops clear-to-send and changes the configuration in the middle of a character, which catches a design that aborts, stretches or re-times a character already in flight. Back-to-back characters check that the next start bit directly follows the final stop tick. A design that waits in idle for one cycle would add an extra tick to every stop period.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_EVEN = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_ZERO = 2'd2,
        PAR_ONE  = 2'd3
    } par_mode_e;

endpackage

// File: rtl/sertx_stop_calc.sv
module sertx_stop_calc #(
    parameter int OVS   = 16,
    parameter int CNT_W = 6
) (
    input  logic [3:0]       code,
    input  logic             len_is_min,
    input  logic             x1_mode,
    output logic [CNT_W-1:0] stop_ticks
);
    localparam int LONG_BASE  = OVS + 1;
    localparam int SHORT_BASE = OVS / 2 + 1;

    always_comb begin
        if (x1_mode) begin
            stop_ticks = code[3] ? CNT_W'(2) : CNT_W'(1);
        end else if (len_is_min || code[3]) begin
            stop_ticks = CNT_W'(LONG_BASE) + CNT_W'(code);
        end else begin
            stop_ticks = CNT_W'(SHORT_BASE) + CNT_W'(code);
        end
    end
endmodule

// File: rtl/sertx_parity.sv
module sertx_parity
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len_sel,
    input  par_mode_e         mode,
    output logic              par_bit
);
    localparam int MIN_BITS = DATA_W - (1 << LEN_W) + 1;

    logic ones_odd;

    always_comb begin
        ones_odd = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < MIN_BITS + int'(len_sel)) begin
                ones_odd = ones_odd ^ data[i];
            end
        end
        unique case (mode)
            PAR_EVEN: par_bit = ones_odd;
            PAR_ODD:  par_bit = ~ones_odd;
            PAR_ZERO: par_bit = 1'b0;
            default:  par_bit = 1'b1;
        endcase
    end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic [1:0]        cfg_par_mode,
    input  logic [3:0]        cfg_stop,
    input  logic              cfg_cts_en,
    input  logic              cfg_x1,
    input  logic              cts_ok,
    output logic              tx_out
);
    localparam int MIN_BITS = DATA_W - (1 << LEN_W) + 1;
    localparam int CNT_W    = $clog2(2 * OVS + 1);
    localparam int IDX_W    = $clog2(DATA_W);

    typedef struct packed {
        tx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last_idx;
        logic [DATA_W-1:0] sh;
        logic              tx;
        logic              par;
        logic              par_en;
        logic [CNT_W-1:0]  bit_ticks;
        logic [CNT_W-1:0]  stop_ticks;
    } core_regs_t;

    core_regs_t q, n;

    logic             accept;
    logic             slot_end;
    logic             cts_gate;
    logic             line_free;
    logic             par_calc;
    logic [CNT_W-1:0] stop_calc;

    sertx_stop_calc #(
        .OVS   (OVS),
        .CNT_W (CNT_W)
    ) u_stop (
        .code       (cfg_stop),
        .len_is_min (cfg_len == '0),
        .x1_mode    (cfg_x1),
        .stop_ticks (stop_calc)
    );

    sertx_parity #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_par (
        .data    (in_data),
        .len_sel (cfg_len),
        .mode    (par_mode_e'(cfg_par_mode)),
        .par_bit (par_calc)
    );

    always_comb begin
        n         = q;
        slot_end  = tick && (q.cnt == CNT_W'(1));
        cts_gate  = !cfg_cts_en || cts_ok;
        line_free = (q.state == ST_IDLE) || ((q.state == ST_STOP) && slot_end);
        in_ready  = line_free && cts_gate;
        accept    = in_valid && in_ready;

        if (tick && (q.state != ST_IDLE) && (q.cnt != '0)) begin
            n.cnt = q.cnt - CNT_W'(1);
        end

        unique case (q.state)
            ST_IDLE: begin
                n.tx = 1'b1;
            end
            ST_START: begin
                if (slot_end) begin
                    n.state = ST_DATA;
                    n.tx    = q.sh[0];
                    n.cnt   = q.bit_ticks;
                    n.idx   = '0;
                end
            end
            ST_DATA: begin
                if (slot_end) begin
                    if (q.idx == q.last_idx) begin
                        if (q.par_en) begin
                            n.state = ST_PARITY;
                            n.tx    = q.par;
                            n.cnt   = q.bit_ticks;
                        end else begin
                            n.state = ST_STOP;
                            n.tx    = 1'b1;
                            n.cnt   = q.stop_ticks;
                        end
                    end else begin
                        n.idx = q.idx + IDX_W'(1);
                        n.sh  = q.sh >> 1;
                        n.tx  = q.sh[1];
                        n.cnt = q.bit_ticks;
                    end
                end
            end
            ST_PARITY: begin
                if (slot_end) begin
                    n.state = ST_STOP;
                    n.tx    = 1'b1;
                    n.cnt   = q.stop_ticks;
                end
            end
            ST_STOP: begin
                if (slot_end) begin
                    n.state = ST_IDLE;
                    n.tx    = 1'b1;
                end
            end
            default: begin
                n.state = ST_IDLE;
                n.tx    = 1'b1;
            end
        endcase

        if (accept) begin
            n.state      = ST_START;
            n.tx         = 1'b0;
            n.bit_ticks  = cfg_x1 ? CNT_W'(1) : CNT_W'(OVS);
            n.cnt        = cfg_x1 ? CNT_W'(1) : CNT_W'(OVS);
            n.idx        = '0;
            n.sh         = in_data;
            n.last_idx   = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_len);
            n.par_en     = cfg_par_en;
            n.par        = par_calc;
            n.stop_ticks = stop_calc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state      <= ST_IDLE;
            q.cnt        <= '0;
            q.idx        <= '0;
            q.last_idx   <= '0;
            q.sh         <= '0;
            q.tx         <= 1'b1;
            q.par        <= 1'b0;
            q.par_en     <= 1'b0;
            q.bit_ticks  <= '0;
            q.stop_ticks <= '0;
        end else begin
            q <= n;
        end
    end

    assign tx_out = q.tx;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> tx_out); // R1

    AST_ACCEPT_GIVES_START: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!tx_out && (q.state == ST_START))); // R2

    AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_STOP) |-> tx_out); // R4

    AST_STOP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cfg_x1) |=> ((q.stop_ticks > CNT_W'(OVS / 2)) && (q.stop_ticks <= CNT_W'(2 * OVS)))); // R5

    AST_X1_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_x1) |=> ((q.bit_ticks == CNT_W'(1)) && (q.stop_ticks <= CNT_W'(2)))); // R6

    AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cfg_cts_en) |-> cts_ok); // R7

    AST_LATCHED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state != ST_IDLE) && !$past(accept)) |-> ($stable(q.stop_ticks) && $stable(q.last_idx))); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_START) || (q.state == ST_DATA) || (q.state == ST_PARITY)) |-> !in_ready); // R11

endmodule

// File: tb/sertx_core_tb.sv
module sertx_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic [3:0] cfg_stop = 4'd7;
    logic       cfg_cts_en = 1'b0;
    logic       cfg_x1 = 1'b0;
    logic       cts_ok = 1'b1;
    logic       tx_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic exp_bits [0:255];
    int   exp_n;

    always #5 clk = ~clk;

    sertx_core dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_mode (cfg_par_mode),
        .cfg_stop     (cfg_stop),
        .cfg_cts_en   (cfg_cts_en),
        .cfg_x1       (cfg_x1),
        .cts_ok       (cts_ok),
        .tx_out       (tx_out)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic v, input int dur);
        for (int k = 0; k < dur; k++) begin
            exp_bits[exp_n] = v;
            exp_n++;
        end
    endtask

    task automatic build_exp(input logic [7:0] d, input logic [1:0] len, input logic pe,
                             input logic [1:0] pm, input logic [3:0] sc, input logic x1);
        int   bt;
        int   nb;
        int   st;
        logic p;
        bt = x1 ? 1 : 16;
        nb = 5 + int'(len);
        if (x1) st = sc[3] ? 2 : 1;
        else if (len == 2'd0 || sc >= 4'd8) st = 17 + int'(sc);
        else st = 9 + int'(sc);
        p = 1'b0;
        for (int i = 0; i < nb; i++) p = p ^ d[i];
        case (pm)
            2'd0: p = p;
            2'd1: p = ~p;
            2'd2: p = 1'b0;
            default: p = 1'b1;
        endcase
        exp_n = 0;
        push(1'b0, bt);
        for (int i = 0; i < nb; i++) push(d[i], bt);
        if (pe) push(p, bt);
        push(1'b1, st);
    endtask

    // mode: 0 plain, 1 change config after accept, 2 drop cts_ok after accept
    task automatic run_frame(input logic [7:0] d, input logic [1:0] len, input logic pe,
                             input logic [1:0] pm, input logic [3:0] sc, input logic x1,
                             input bit keep, input int mode, input string tag);
        int first_bad;
        int act_bit;
        in_data = d; cfg_len = len; cfg_par_en = pe; cfg_par_mode = pm;
        cfg_stop = sc; cfg_x1 = x1; in_valid = 1'b1;
        #1;
        check(tag, "ready before start", int'(in_ready), 1);
        build_exp(d, len, pe, pm, sc, x1);
        @(posedge clk);
        @(negedge clk);
        if (!keep) in_valid = 1'b0;
        if (mode == 1) begin
            cfg_stop = ~sc; cfg_len = ~len; cfg_par_en = ~pe; cfg_par_mode = ~pm;
        end
        if (mode == 2) cts_ok = 1'b0;
        first_bad = -1;
        act_bit = 0;
        for (int i = 0; i < exp_n; i++) begin
            if (i > 0) @(negedge clk);
            if (first_bad < 0 && tx_out !== exp_bits[i]) begin
                first_bad = i;
                act_bit = int'(tx_out);
            end
        end
        if (first_bad < 0) check(tag, "frame waveform", 0, 0);
        else check(tag, $sformatf("frame bit at cycle %0d", first_bad), act_bit, int'(exp_bits[first_bad]));
        if (mode != 2) check("R11", "ready in final stop tick", int'(in_ready), 1);
    endtask

    task automatic idle_gap(input int cyc);
        in_valid = 1'b0;
        repeat (cyc) @(negedge clk);
        check("R1", "idle line high", int'(tx_out), 1);
    endtask

    task automatic t_reset;
        check("R1", "tx after reset", int'(tx_out), 1);
        check("R1", "ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_formats;
        run_frame(8'hA5, 2'd3, 1'b0, 2'd0, 4'd7, 1'b0, 1'b0, 0, "R2");
        idle_gap(3);
        run_frame(8'hE6, 2'd0, 1'b0, 2'd0, 4'd3, 1'b0, 1'b0, 0, "R2");
        idle_gap(3);
        run_frame(8'h2B, 2'd1, 1'b1, 2'd0, 4'd7, 1'b0, 1'b0, 0, "R3");
        idle_gap(2);
        run_frame(8'h55, 2'd2, 1'b1, 2'd1, 4'd7, 1'b0, 1'b0, 0, "R3");
        idle_gap(2);
        run_frame(8'hFF, 2'd3, 1'b1, 2'd2, 4'd7, 1'b0, 1'b0, 0, "R3");
        idle_gap(2);
        run_frame(8'h00, 2'd3, 1'b1, 2'd3, 4'd7, 1'b0, 1'b0, 0, "R3");
        idle_gap(2);
    endtask

    task automatic t_stop_long;
        run_frame(8'h3C, 2'd3, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 0, "R4");
        idle_gap(2);
        run_frame(8'h81, 2'd2, 1'b0, 2'd0, 4'd8, 1'b0, 1'b0, 0, "R4");
        idle_gap(2);
        run_frame(8'h5A, 2'd1, 1'b1, 2'd0, 4'd15, 1'b0, 1'b0, 0, "R4");
        idle_gap(2);
    endtask

    task automatic t_stop_five;
        run_frame(8'h15, 2'd0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 0, "R5");
        idle_gap(2);
        run_frame(8'h0A, 2'd0, 1'b1, 2'd1, 4'd7, 1'b0, 1'b0, 0, "R5");
        idle_gap(2);
        run_frame(8'h1F, 2'd0, 1'b0, 2'd0, 4'd15, 1'b0, 1'b0, 0, "R5");
        idle_gap(2);
    endtask

    task automatic t_x1;
        run_frame(8'hC3, 2'd3, 1'b1, 2'd0, 4'd7, 1'b1, 1'b0, 0, "R6");
        idle_gap(2);
        run_frame(8'h96, 2'd1, 1'b0, 2'd0, 4'd8, 1'b1, 1'b0, 0, "R6");
        idle_gap(2);
    endtask

    task automatic t_cts_block;
        int seen_low;
        int seen_ready;
        cfg_cts_en = 1'b1; cts_ok = 1'b0;
        in_data = 8'h3C; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 4'd7; cfg_x1 = 1'b0;
        in_valid = 1'b1;
        seen_low = 0; seen_ready = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (!tx_out) seen_low++;
            if (in_ready) seen_ready++;
        end
        check("R7", "line low while blocked", seen_low, 0);
        check("R7", "ready while blocked", seen_ready, 0);
        cts_ok = 1'b1;
        run_frame(8'h3C, 2'd3, 1'b0, 2'd0, 4'd7, 1'b0, 1'b0, 0, "R7");
        idle_gap(2);
    endtask

    task automatic t_cts_mid;
        cfg_cts_en = 1'b1; cts_ok = 1'b1;
        run_frame(8'h69, 2'd3, 1'b1, 2'd0, 4'd12, 1'b0, 1'b0, 2, "R8");
        cts_ok = 1'b1;
        cfg_cts_en = 1'b0;
        idle_gap(2);
    endtask

    task automatic t_cts_off;
        cfg_cts_en = 1'b0; cts_ok = 1'b0;
        run_frame(8'hB4, 2'd3, 1'b0, 2'd0, 4'd7, 1'b0, 1'b0, 0, "R9");
        cts_ok = 1'b1;
        idle_gap(2);
    endtask

    task automatic t_cfg_latch;
        run_frame(8'h4D, 2'd2, 1'b1, 2'd1, 4'd2, 1'b0, 1'b0, 1, "R10");
        idle_gap(2);
    endtask

    task automatic t_back_to_back;
        run_frame(8'h12, 2'd3, 1'b0, 2'd0, 4'd1, 1'b0, 1'b1, 0, "R11");
        run_frame(8'hED, 2'd3, 1'b1, 2'd0, 4'd9, 1'b0, 1'b1, 0, "R11");
        run_frame(8'h07, 2'd0, 1'b0, 2'd0, 4'd4, 1'b0, 1'b0, 0, "R11");
        idle_gap(2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_formats();
        t_stop_long();
        t_stop_five();
        t_x1();
        t_cts_block();
        t_cts_mid();
        t_cts_off();
        t_cfg_latch();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule